// File: doc/BRIEF.md
# 64-bit Integer ALU with Three-Way Compare

This unit executes the integer arithmetic, bitwise, shift, negation and compare operations of a byte-coded register machine. Each operation carries an 8-bit opcode and a first operand from a register. It also carries two candidates for the second operand: a register value and a decoded 64-bit immediate. The opcode alone picks which candidate is used. Register forms sit at opcodes 1 to 14 and immediate forms at 18 to 27, and both forms share one datapath.

Compares produce no flags. They write a full 64-bit word: all-ones when the first operand is smaller, zero when the operands are equal and one when the first operand is larger. There is a signed and an unsigned variant. Any opcode the unit does not execute returns zero and raises an illegal-operation flag, so the surrounding core can raise its invalid-opcode trap.

Operations enter through a valid/ready stream and leave through a second valid/ready stream, with one register stage between them. An operation is accepted in any cycle where `in_valid` and `in_ready` are both high. Its result appears on the output in the next cycle. A result stays on the output, unchanged, until the cycle in which `out_ready` is high. While that result is stalled, `in_ready` is low. In a cycle where the result drains, a new operation can be accepted in that same cycle.

Top module: `int_alu64`

## Requirements
- R1: Opcodes 1, 2 and 3 give a+b, a-b and the low 64 bits of a*b, each wrapping modulo 2^64.
- R2: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of a and b.
- R3: Opcode 7 shifts a left, opcode 8 shifts a right with zero fill, and opcode 9 shifts a right with sign fill. The shift amount is bits [5:0] of b, and the higher bits of b are ignored.
- R4: Opcode 10 compares a with b as signed two's-complement numbers. The result is 64'hFFFF_FFFF_FFFF_FFFF when a<b, 0 when a==b and 1 when a>b.
- R5: Opcode 11 makes the same three-way compare as R4, with both operands treated as unsigned.
- R6: Opcode 13 gives the bitwise complement of a, and b has no effect on it.
- R7: Opcode 14 gives 1 when a is zero and 0 otherwise.
- R8: Opcodes 18 to 27 take in_imm as the second operand, and in_b has no effect on them. The mapping is 18 add, 19 multiply, 20 AND, 21 OR, 22 XOR, 23 left shift, 24 logical right shift, 25 arithmetic right shift, 26 signed compare and 27 unsigned compare.
- R9: For opcodes 1 to 14, in_imm has no effect on the result.
- R10: Every other opcode value (0, 12, 15 to 17, and 28 to 255) gives a result of zero with out_illegal high. Every supported opcode gives out_illegal low.
- R11: An operation accepted in a cycle is presented with out_valid high in the next cycle. While out_ready is low, out_valid, out_result and out_illegal hold steady.
- R12: in_ready is high exactly when the output register is empty or is draining in that cycle. This lets a new operation be accepted in the same cycle that the previous result is taken.
- R13: While rst_n is low, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_op | input | 8 | Opcode |
| in_a | input | 64 | First operand (register) |
| in_b | input | 64 | Second operand, register form |
| in_imm | input | 64 | Second operand, immediate form |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 64 | Result word |
| out_illegal | output | 1 | The opcode was not executable by the unit |

## Verification
Two events can fall in the same cycle: the draining of a held result and the acceptance of the next operation. The bench provokes this by stalling the output with out_ready low while a second operation waits on in_valid. It first checks that in_ready stays low and that the held result does not change. It then raises out_ready, and checks that the waiting operation is accepted in that cycle and that its own result follows one cycle later. A further check covers the case where an illegal opcode is the one stalled: its zero result and flag must hold together for as long as the stall lasts.

// File: rtl/int_alu64_pkg.sv
package int_alu64_pkg;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_MUL, FN_AND, FN_OR, FN_XOR,
    FN_SHL, FN_SHR, FN_SAR, FN_CMPS, FN_CMPU,
    FN_BNOT, FN_LNOT, FN_NONE
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    use_imm;
    logic    illegal;
  } alu_ctl_t;

endpackage

// File: rtl/int_alu64_decode.sv
module int_alu64_decode
  import int_alu64_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output alu_ctl_t        ctl
);

  always_comb begin
    ctl.fn      = FN_NONE;
    ctl.use_imm = 1'b0;
    ctl.illegal = 1'b0;
    case (op)
      OP_W'(1):  ctl.fn = FN_ADD;
      OP_W'(2):  ctl.fn = FN_SUB;
      OP_W'(3):  ctl.fn = FN_MUL;
      OP_W'(4):  ctl.fn = FN_AND;
      OP_W'(5):  ctl.fn = FN_OR;
      OP_W'(6):  ctl.fn = FN_XOR;
      OP_W'(7):  ctl.fn = FN_SHL;
      OP_W'(8):  ctl.fn = FN_SHR;
      OP_W'(9):  ctl.fn = FN_SAR;
      OP_W'(10): ctl.fn = FN_CMPS;
      OP_W'(11): ctl.fn = FN_CMPU;
      OP_W'(13): ctl.fn = FN_BNOT;
      OP_W'(14): ctl.fn = FN_LNOT;
      OP_W'(18): begin ctl.fn = FN_ADD;  ctl.use_imm = 1'b1; end
      OP_W'(19): begin ctl.fn = FN_MUL;  ctl.use_imm = 1'b1; end
      OP_W'(20): begin ctl.fn = FN_AND;  ctl.use_imm = 1'b1; end
      OP_W'(21): begin ctl.fn = FN_OR;   ctl.use_imm = 1'b1; end
      OP_W'(22): begin ctl.fn = FN_XOR;  ctl.use_imm = 1'b1; end
      OP_W'(23): begin ctl.fn = FN_SHL;  ctl.use_imm = 1'b1; end
      OP_W'(24): begin ctl.fn = FN_SHR;  ctl.use_imm = 1'b1; end
      OP_W'(25): begin ctl.fn = FN_SAR;  ctl.use_imm = 1'b1; end
      OP_W'(26): begin ctl.fn = FN_CMPS; ctl.use_imm = 1'b1; end
      OP_W'(27): begin ctl.fn = FN_CMPU; ctl.use_imm = 1'b1; end
      default:   ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/int_alu64_shift.sv
module int_alu64_shift #(
  parameter int DATA_W = 64,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SH_W-1:0]   amt,
  input  logic              arith,
  output logic [DATA_W-1:0] shl,
  output logic [DATA_W-1:0] shr
);

  logic                fill;
  logic [DATA_W-1:0]   lstg [SH_W+1];
  logic [DATA_W-1:0]   rstg [SH_W+1];

  assign fill    = arith & val[DATA_W-1];
  assign lstg[0] = val;
  assign rstg[0] = val;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign lstg[k+1] = amt[k] ? {lstg[k][DATA_W-1-S:0], {S{1'b0}}} : lstg[k];
    assign rstg[k+1] = amt[k] ? {{S{fill}}, rstg[k][DATA_W-1:S]} : rstg[k];
  end

  assign shl = lstg[SH_W];
  assign shr = rstg[SH_W];

endmodule

// File: rtl/int_alu64_cmp.sv
module int_alu64_cmp #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              signed_mode,
  output logic [DATA_W-1:0] ord
);

  logic lt, eq;

  always_comb begin
    eq = (a == b);
    if (signed_mode) lt = ($signed(a) < $signed(b));
    else             lt = (a < b);
    if (lt)      ord = '1;
    else if (eq) ord = '0;
    else         ord = DATA_W'(1);
  end

endmodule

// File: rtl/int_alu64.sv
module int_alu64
  import int_alu64_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam int SH_W = $clog2(DATA_W);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] shl_v, shr_v, cmp_v;
  logic [DATA_W-1:0] res;
  logic              take;

  int_alu64_decode #(.OP_W(OP_W)) u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  assign opb = ctl.use_imm ? in_imm : in_b;

  int_alu64_shift #(.DATA_W(DATA_W)) u_shf (
    .val   (in_a),
    .amt   (opb[SH_W-1:0]),
    .arith (ctl.fn == FN_SAR),
    .shl   (shl_v),
    .shr   (shr_v)
  );

  int_alu64_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a           (in_a),
    .b           (opb),
    .signed_mode (ctl.fn == FN_CMPS),
    .ord         (cmp_v)
  );

  always_comb begin
    unique case (ctl.fn)
      FN_ADD:  res = in_a + opb;
      FN_SUB:  res = in_a - opb;
      FN_MUL:  res = in_a * opb;
      FN_AND:  res = in_a & opb;
      FN_OR:   res = in_a | opb;
      FN_XOR:  res = in_a ^ opb;
      FN_SHL:  res = shl_v;
      FN_SHR:  res = shr_v;
      FN_SAR:  res = shr_v;
      FN_CMPS: res = cmp_v;
      FN_CMPU: res = cmp_v;
      FN_BNOT: res = ~in_a;
      FN_LNOT: res = DATA_W'(in_a == '0);
      default: res = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= take;
      if (take) begin
        out_result  <= res;
        out_illegal <= ctl.illegal;
      end
    end
  end

endmodule

// File: rtl/int_alu64_chk.sv
module int_alu64_chk #(
  parameter int DATA_W = 64,
  parameter int OP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);

  logic [OP_W-1:0] held_op;
  logic            is_cmp, is_lnot;

  always_ff @(posedge clk) begin
    if (!rst_n) held_op <= '0;
    else if (in_valid && in_ready) held_op <= in_op;
  end

  assign is_cmp  = (held_op == OP_W'(10)) || (held_op == OP_W'(11)) ||
                   (held_op == OP_W'(26)) || (held_op == OP_W'(27));
  assign is_lnot = (held_op == OP_W'(14));

  // R11
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));

  // R12
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);

  // R4 R5
  cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_cmp |-> (out_result == '0) || (out_result == DATA_W'(1)) || (&out_result));

  // R7
  lnot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_lnot |-> out_result[DATA_W-1:1] == '0);

endmodule

bind int_alu64 int_alu64_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/int_alu64_tb.sv
module int_alu64_tb;

  typedef struct packed {
    logic [7:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] imm;
    logic [63:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 26;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VEC [NV] = '{
    '{8'd1,  ONES, 64'd2, 64'd0, 64'd1, 1'b0},                                   // R1 add wrap
    '{8'd2,  64'd0, 64'd1, 64'd0, ONES, 1'b0},                                   // R1 sub wrap
    '{8'd3,  64'h1_0000_0001, 64'h1_0000_0001, 64'd0, 64'h2_0000_0001, 1'b0},    // R1 mul low
    '{8'd4,  64'hF0F0, 64'hFF00, 64'd0, 64'hF000, 1'b0},                         // R2
    '{8'd5,  64'hF0F0, 64'hFF00, 64'd0, 64'hFFF0, 1'b0},                         // R2
    '{8'd6,  64'hF0F0, 64'hFF00, 64'd0, 64'h0FF0, 1'b0},                         // R2
    '{8'd7,  64'd1, 64'h43, 64'd0, 64'd8, 1'b0},                                 // R3 amount 3
    '{8'd8,  64'h8000_0000_0000_0000, 64'd63, 64'd0, 64'd1, 1'b0},               // R3
    '{8'd9,  64'h8000_0000_0000_0000, 64'd4, 64'd0, 64'hF800_0000_0000_0000, 1'b0}, // R3
    '{8'd10, ONES, 64'd1, 64'd0, ONES, 1'b0},                                    // R4 lt
    '{8'd10, 64'd5, 64'd5, 64'd0, 64'd0, 1'b0},                                  // R4 eq
    '{8'd10, 64'd1, ONES, 64'd0, 64'd1, 1'b0},                                   // R4 gt
    '{8'd11, ONES, 64'd1, 64'd0, 64'd1, 1'b0},                                   // R5 gt
    '{8'd11, 64'd1, ONES, 64'd0, ONES, 1'b0},                                    // R5 lt
    '{8'd13, 64'h00FF, 64'd123, 64'd0, 64'hFFFF_FFFF_FFFF_FF00, 1'b0},           // R6
    '{8'd14, 64'd0, 64'd9, 64'd0, 64'd1, 1'b0},                                  // R7
    '{8'd14, 64'd7, 64'd0, 64'd0, 64'd0, 1'b0},                                  // R7
    '{8'd18, 64'd10, 64'd999, 64'd5, 64'd15, 1'b0},                              // R8
    '{8'd19, 64'd3, 64'd7, ONES, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0},                 // R8
    '{8'd24, 64'h100, 64'd1, 64'h44, 64'h10, 1'b0},                              // R8
    '{8'd25, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 64'd2, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0}, // R8
    '{8'd26, 64'd2, 64'd9, ONES, 64'd1, 1'b0},                                   // R8
    '{8'd27, 64'd2, 64'd9, ONES, ONES, 1'b0},                                    // R8
    '{8'd1,  64'd1, 64'd2, 64'd100, 64'd3, 1'b0},                                // R9
    '{8'd12, 64'd5, 64'd6, 64'd7, 64'd0, 1'b1},                                  // R10
    '{8'd200, 64'd5, 64'd6, 64'd7, 64'd0, 1'b1}                                  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [7:0]  in_op;
  logic [63:0] in_a, in_b, in_imm;
  logic        out_valid, out_ready, out_illegal;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  int_alu64 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_in(input logic [7:0] op, input logic [63:0] a, b, imm);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_imm = imm;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_a = '0; in_b = '0; in_imm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 out_valid in reset", 64'(out_valid), 64'd0);
    check("R13 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // vector table, one operation per pass, sampled on the following negedge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_in(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].imm);
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R11 valid vec %0d", i), 64'(out_valid), 64'd1);
      check($sformatf("R1-9 result op %0d vec %0d", VEC[i].op, i), out_result, VEC[i].exp);
      check($sformatf("R10 illegal flag vec %0d", i), 64'(out_illegal), 64'(VEC[i].ill));
    end

    // R12 back-pressure and same-cycle drain plus accept
    @(negedge clk);
    out_ready = 1'b0;
    set_in(8'd1, 64'd40, 64'd2, 64'd0);
    @(posedge clk);
    #1 set_in(8'd2, 64'd40, 64'd2, 64'd0);
    @(negedge clk);
    check("R12 in_ready low while stalled", 64'(in_ready), 64'd0);
    check("R11 result held", out_result, 64'd42);
    @(negedge clk);
    check("R11 result still held", out_result, 64'd42);
    check("R11 valid held", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    #1;
    check("R12 in_ready during drain", 64'(in_ready), 64'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R12 next result after drain", out_result, 64'd38);
    check("R12 valid after drain", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R11 empty after take", 64'(out_valid), 64'd0);

    // R10 stalled illegal result holds flag and zero
    out_ready = 1'b0;
    set_in(8'd0, 64'd3, 64'd3, 64'd3);
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 stalled illegal result", out_result, 64'd0);
    check("R10 stalled illegal flag", 64'(out_illegal), 64'd1);
    out_ready = 1'b1;

    // R6 b has no effect on complement; R8 b ignored for immediate form
    @(negedge clk);
    set_in(8'd13, 64'h1234, ONES, 64'd0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R6 complement with b ones", out_result, ~64'h1234);
    set_in(8'd20, 64'hFF, 64'h0F, 64'hF0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R8 andi uses imm", out_result, 64'hF0);

    @(negedge clk);
    finish_run();
  end

endmodule